// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Holding and Status Registers

This block takes a single serial line and rebuilds characters from it. It uses a sampling enable that pulses sixteen times per bit period. The receiver waits for a falling edge on the idle-high line and checks the start bit at its centre. It then takes seven or eight data bits, least significant first, an optional parity bit and one stop bit, each sampled at the centre of its bit cell.

When a character ends, the word moves from the shift register into a holding register. The receiver then raises a full flag and pulses an interrupt for one cycle. It also latches three error flags for that word: a bad start bit, a parity mismatch and a missing stop bit. A read strobe on the holding register clears the full flag. If a word arrives while the previous one was never read, the older word is overwritten and an overrun flag is set. The overrun flag stays set until any write to the status register. A busy flag covers the time from start detection until the word is handed over.

Top module: `uart_rx_status`

## Requirements
- R1: When a finished word is handed to the holding register, `stat_full` becomes 1 and `irq_rx` is high for exactly one clock cycle. Each received character produces exactly one pulse.
- R2: A one-cycle `bus_rd_data` strobe clears `stat_full` on the next clock edge and leaves the other flags unchanged.
- R3: If a word is handed over while `stat_full` is 1, `stat_overrun` becomes 1 and `data_out` shows the newer word.
- R4: A `bus_wr_status` strobe clears `stat_overrun`. Reading the holding register does not clear it.
- R5: With `cfg_par_en`=1, `stat_parity_err` is set when the received parity bit breaks the selected rule. With `cfg_par_odd`=0 the data bits plus the parity bit must hold an even number of ones. With `cfg_par_odd`=1 they must hold an odd number of ones.
- R6: With `cfg_par_en`=0 no parity bit is expected, and `stat_parity_err` is 0 after every word.
- R7: `stat_start_err` is set for a word whose start bit is found high at its centre sample.
- R8: `stat_frame_err` is set for a word whose stop bit is sampled low.
- R9: Data bits arrive least significant first. With `cfg_bits8`=1 all eight bits land in `data_out[7:0]`. With `cfg_bits8`=0 seven bits land in `data_out[6:0]` and `data_out[7]` is 0.
- R10: `stat_busy` is 1 while a character is being received. It is 0 once the word has been handed over.
- R11: The start, parity and frame error flags are rewritten at every hand-over, so a clean word clears earlier errors. Between hand-overs the flags and `data_out` hold their values.
- R12: After reset all flags are 0, `data_out` is 0, `irq_rx` is 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sampling enable, 16 pulses per bit period |
| rx_in | input | 1 | Serial line, idle high |
| cfg_bits8 | input | 1 | 1 selects eight data bits, 0 selects seven |
| cfg_par_en | input | 1 | 1 expects a parity bit after the data |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| bus_rd_data | input | 1 | Read strobe for the holding register |
| bus_wr_status | input | 1 | Write strobe for the status register |
| data_out | output | 8 | Holding register contents |
| stat_busy | output | 1 | Character reception in progress |
| stat_full | output | 1 | Holding register has unread data |
| stat_overrun | output | 1 | An unread word was overwritten |
| stat_start_err | output | 1 | Start-bit error on the last word |
| stat_parity_err | output | 1 | Parity error on the last word |
| stat_frame_err | output | 1 | Stop-bit error on the last word |
| irq_rx | output | 1 | One-cycle pulse at each hand-over |

## Verification
Two situations are the hardest to produce from the pins. The first is a start error: the line must fall, so that reception begins, and then rise again before the centre sample. The bench makes a short low glitch, returns the line high for the rest of the start cell, and then drives the data bits as usual. The second is an overrun: two full characters must arrive with no read strobe between them. The bench then checks that a read leaves the overrun flag set and that only a status write clears it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       start_err;
        logic       par_err;
        logic       frame_err;
    } rx_word_t;

    function automatic logic par_mismatch(input logic [7:0] d,
                                          input logic       pbit,
                                          input logic       odd);
        return (^d) ^ pbit ^ odd;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], rx_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign rx_s = chain[STAGES-1];
    assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx_s,
    input  logic     fall,
    input  logic     bits8,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     busy,
    output logic     xfer,
    output rx_word_t word
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BN_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BN_W-1:0]   bitn;
    logic [DATA_W-1:0] shreg;
    logic              st_err;
    logic              pbit;
    logic [BN_W-1:0]   nbits;
    logic [7:0]        aligned;

    assign nbits   = bits8 ? BN_W'(DATA_W) : BN_W'(DATA_W - 1);
    assign aligned = bits8 ? shreg : {1'b0, shreg[DATA_W-1:1]};
    assign busy    = (state != RX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            st_err <= 1'b0;
            pbit   <= 1'b0;
            xfer   <= 1'b0;
            word   <= '0;
        end else begin
            xfer <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (fall) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: if (tick) begin
                    if (cnt == MID) begin
                        st_err <= rx_s;
                        cnt    <= '0;
                        bitn   <= '0;
                        state  <= RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: if (tick) begin
                    if (cnt == LAST) begin
                        shreg <= {rx_s, shreg[DATA_W-1:1]};
                        cnt   <= '0;
                        bitn  <= bitn + 1'b1;
                        if (bitn == nbits - 1'b1)
                            state <= par_en ? RX_PAR : RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PAR: if (tick) begin
                    if (cnt == LAST) begin
                        pbit  <= rx_s;
                        cnt   <= '0;
                        state <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    if (cnt == LAST) begin
                        xfer           <= 1'b1;
                        word.data      <= aligned;
                        word.start_err <= st_err;
                        word.par_err   <= par_en & par_mismatch(aligned, pbit, par_odd);
                        word.frame_err <= ~rx_s;
                        cnt            <= '0;
                        state          <= RX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer,
    input  rx_word_t   word,
    input  logic       rd_data,
    input  logic       wr_status,
    output logic [7:0] data_q,
    output logic       full,
    output logic       overrun,
    output logic       start_err,
    output logic       par_err,
    output logic       frame_err,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            full      <= 1'b0;
            overrun   <= 1'b0;
            start_err <= 1'b0;
            par_err   <= 1'b0;
            frame_err <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= xfer;
            if (xfer) begin
                data_q    <= word.data;
                start_err <= word.start_err;
                par_err   <= word.par_err;
                frame_err <= word.frame_err;
                full      <= 1'b1;
            end else if (rd_data) begin
                full <= 1'b0;
            end
            if (xfer && full && !rd_data)
                overrun <= 1'b1;
            else if (wr_status)
                overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic       cfg_bits8,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       bus_rd_data,
    input  logic       bus_wr_status,
    output logic [7:0] data_out,
    output logic       stat_busy,
    output logic       stat_full,
    output logic       stat_overrun,
    output logic       stat_start_err,
    output logic       stat_parity_err,
    output logic       stat_frame_err,
    output logic       irq_rx
);
    localparam int DATA_W = 8;

    logic     rx_s;
    logic     fall;
    logic     xfer;
    rx_word_t word;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx_in),
        .rx_s  (rx_s),
        .fall  (fall)
    );

    uart_rx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .rx_s    (rx_s),
        .fall    (fall),
        .bits8   (cfg_bits8),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .busy    (stat_busy),
        .xfer    (xfer),
        .word    (word)
    );

    uart_rx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .xfer      (xfer),
        .word      (word),
        .rd_data   (bus_rd_data),
        .wr_status (bus_wr_status),
        .data_q    (data_out),
        .full      (stat_full),
        .overrun   (stat_overrun),
        .start_err (stat_start_err),
        .par_err   (stat_parity_err),
        .frame_err (stat_frame_err),
        .irq       (irq_rx)
    );
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_par_en,
    input logic       bus_rd_data,
    input logic       bus_wr_status,
    input logic [7:0] data_out,
    input logic       stat_busy,
    input logic       stat_full,
    input logic       stat_overrun,
    input logic       stat_start_err,
    input logic       stat_parity_err,
    input logic       stat_frame_err,
    input logic       irq_rx
);
    assert_irq_full_R1: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> stat_full);

    assert_irq_single_R1: assert property (@(posedge clk) disable iff (rst)
        irq_rx |=> !irq_rx);

    assert_read_clears_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rd_data |=> (!stat_full || irq_rx));

    assert_overrun_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_overrun) |-> (irq_rx && $past(stat_full)));

    assert_wr_clears_R4: assert property (@(posedge clk) disable iff (rst)
        bus_wr_status |=> (!stat_overrun || irq_rx));

    assert_no_parity_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_rx && !$past(cfg_par_en)) |-> !stat_parity_err);

    assert_busy_end_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_busy) |=> irq_rx);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !irq_rx |-> ($stable(data_out) && $stable(stat_start_err)
                     && $stable(stat_parity_err) && $stable(stat_frame_err)));
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_par_en      (cfg_par_en),
    .bus_rd_data     (bus_rd_data),
    .bus_wr_status   (bus_wr_status),
    .data_out        (data_out),
    .stat_busy       (stat_busy),
    .stat_full       (stat_full),
    .stat_overrun    (stat_overrun),
    .stat_start_err  (stat_start_err),
    .stat_parity_err (stat_parity_err),
    .stat_frame_err  (stat_frame_err),
    .irq_rx          (irq_rx)
);

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
    localparam int BIT_CLKS = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16;
    logic       rx_in = 1'b1;
    logic       cfg_bits8 = 1'b1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       bus_rd_data = 1'b0;
    logic       bus_wr_status = 1'b0;
    logic [7:0] data_out;
    logic       stat_busy, stat_full, stat_overrun;
    logic       stat_start_err, stat_parity_err, stat_frame_err, irq_rx;

    int n_checks = 0;
    int n_fail   = 0;
    int irq_cnt  = 0;
    logic [1:0] tdiv = '0;
    logic busy_mid;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        if (irq_rx) irq_cnt <= irq_cnt + 1;
    end
    assign tick16 = (tdiv == 2'd3);

    uart_rx_status u_uart_rx_status (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in),
        .cfg_bits8(cfg_bits8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .bus_rd_data(bus_rd_data), .bus_wr_status(bus_wr_status),
        .data_out(data_out), .stat_busy(stat_busy), .stat_full(stat_full),
        .stat_overrun(stat_overrun), .stat_start_err(stat_start_err),
        .stat_parity_err(stat_parity_err), .stat_frame_err(stat_frame_err),
        .irq_rx(irq_rx)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx_in = v;
        repeat (BIT_CLKS) @(posedge clk);
    endtask

    // Drives one character; the parity bit is flipped when pflip is set.
    task automatic send(input logic [7:0] d, input logic b8, input logic pen,
                        input logic podd, input logic pflip,
                        input logic stopv, input logic badstart);
        logic [7:0] dm;
        logic p;
        dm = b8 ? d : {1'b0, d[6:0]};
        p  = (^dm) ^ podd ^ pflip;
        @(negedge clk);
        cfg_bits8 = b8; cfg_par_en = pen; cfg_par_odd = podd;
        if (badstart) begin
            rx_in = 1'b0;
            repeat (16) @(posedge clk);
            rx_in = 1'b1;
            repeat (BIT_CLKS - 16) @(posedge clk);
        end else begin
            hold_bit(1'b0);
        end
        busy_mid = stat_busy;
        for (int i = 0; i < (b8 ? 8 : 7); i++) hold_bit(dm[i]);
        if (pen) hold_bit(p);
        hold_bit(stopv);
        rx_in = 1'b1;
        repeat (BIT_CLKS) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_pulse();
        @(negedge clk); bus_rd_data = 1'b1;
        @(negedge clk); bus_rd_data = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_pulse();
        @(negedge clk); bus_wr_status = 1'b1;
        @(negedge clk); bus_wr_status = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R12 data", data_out, 0);
        check("R12 flags", {stat_busy, stat_full, stat_overrun, stat_start_err,
                            stat_parity_err, stat_frame_err, irq_rx}, 0);
    endtask

    task automatic t_basic8();
        int c0 = irq_cnt;
        send(8'hA5, 1, 0, 0, 0, 1, 0);
        check("R10 busy mid frame", busy_mid, 1);
        check("R10 busy after", stat_busy, 0);
        check("R1 full", stat_full, 1);
        check("R1 one irq", irq_cnt - c0, 1);
        check("R9 data 8 bit", data_out, 8'hA5);
        check("R6 no parity err", stat_parity_err, 0);
        check("R8 no frame err", stat_frame_err, 0);
        rd_pulse();
        check("R2 full cleared", stat_full, 0);
        check("R2 data kept", data_out, 8'hA5);
    endtask

    task automatic t_seven();
        send(8'hD3, 0, 0, 0, 0, 1, 0);
        check("R9 data 7 bit", data_out, 8'h53);
        rd_pulse();
    endtask

    task automatic t_parity();
        send(8'h3C, 1, 1, 0, 0, 1, 0);
        check("R5 even ok", stat_parity_err, 0);
        check("R5 even data", data_out, 8'h3C);
        rd_pulse();
        send(8'h3C, 1, 1, 0, 1, 1, 0);
        check("R5 even bad", stat_parity_err, 1);
        rd_pulse();
        send(8'h71, 0, 1, 1, 0, 1, 0);
        check("R5 odd ok", stat_parity_err, 0);
        check("R11 parity cleared", stat_parity_err, 0);
        check("R9 7 bit with parity", data_out, 8'h71);
        rd_pulse();
        send(8'h71, 0, 1, 1, 1, 1, 0);
        check("R5 odd bad", stat_parity_err, 1);
        rd_pulse();
        send(8'h01, 1, 0, 0, 0, 1, 0);
        check("R6 disabled clears", stat_parity_err, 0);
        rd_pulse();
    endtask

    task automatic t_frame();
        send(8'h5E, 1, 0, 0, 0, 0, 0);
        check("R8 frame err", stat_frame_err, 1);
        check("R8 data", data_out, 8'h5E);
        rd_pulse();
        check("R11 flag holds after read", stat_frame_err, 1);
        send(8'h11, 1, 0, 0, 0, 1, 0);
        check("R11 frame cleared", stat_frame_err, 0);
        rd_pulse();
    endtask

    task automatic t_start();
        send(8'hFF, 1, 0, 0, 0, 1, 1);
        check("R7 start err", stat_start_err, 1);
        rd_pulse();
        send(8'h22, 1, 0, 0, 0, 1, 0);
        check("R11 start cleared", stat_start_err, 0);
        check("R11 data", data_out, 8'h22);
        rd_pulse();
    endtask

    task automatic t_overrun();
        int c0 = irq_cnt;
        send(8'h12, 1, 0, 0, 0, 1, 0);
        check("R3 no overrun yet", stat_overrun, 0);
        send(8'h34, 1, 0, 0, 0, 1, 0);
        check("R3 overrun", stat_overrun, 1);
        check("R3 newer data", data_out, 8'h34);
        check("R1 two irqs", irq_cnt - c0, 2);
        rd_pulse();
        check("R4 read keeps overrun", stat_overrun, 1);
        check("R2 full cleared", stat_full, 0);
        wr_pulse();
        check("R4 write clears overrun", stat_overrun, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_basic8();
        t_seven();
        t_parity();
        t_frame();
        t_start();
        t_overrun();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule